// File: doc/BRIEF.md
# (72,64) SECDED Hamming Codec

This block protects 64-bit words with an extended Hamming code and eight check bits. The encoder side turns eight data bytes into a nine-byte, 72-bit codeword. The check bits sit at the power-of-two positions (1, 2, 4, 8, 16, 32, 64). An overall parity bit sits at position 0, and the data bits fill the remaining positions in ascending order. The decoder side takes a nine-byte codeword and returns eight corrected data bytes. It also raises exactly one of three verdict flags: clean, fixed or double.

The two sides are independent datapaths that share one optional output register stage. With `REG_OUT` set (the default), every output follows its inputs one clock later and reset clears the outputs to zero. With `REG_OUT` cleared, both sides are purely combinational. The decoder has three outcomes:

- **Clean:** it passes the data through.
- **Fixed:** it repairs any single flipped bit, including the overall parity bit.
- **Double:** it reports a double error when the syndrome is nonzero and the overall parity matches. It also raises this flag when the syndrome points past position 71. In both cases it returns the raw, unrepaired data bits.

Top module: `secded72_codec`

## Requirements
- R1: Data bit d(i) lands at the i-th non-check position of the codeword counted upward from position 3: d0 at position 3, d1..d3 at 5..7, d4..d10 at 9..15, and so on up to d57..d63 at 65..71. Positions 0, 1, 2, 4, 8, 16, 32 and 64 hold check bits only.
- R2: The check bit at position 2^k (k = 0..6) gives even parity over all codeword positions whose index has bit k set, itself included.
- R3: The bit at position 0 makes the XOR of all 72 codeword bits equal zero.
- R4: Lanes are byte slices.
  - Data lane j bit b is d(8j+b).
  - Codeword lane j bit b is position 8j+b.
  - Both sides use the same mapping.
- R5: A codeword that matches the code (zero syndrome, even overall parity) raises only `dec_clean` and returns the data bits unchanged.
- R6: A codeword with one flipped bit at any position 1..71 raises only `dec_fixed` and returns the original data.
  - The syndrome is nonzero and the overall parity is odd.
  - The syndrome is the XOR of the indices of all set positions, and the decoder flips the bit at the position the syndrome names.
- R7: A codeword whose only error is at position 0 (zero syndrome, odd overall parity) raises only `dec_fixed` and returns the original data.
- R8: A codeword with two flipped bits (nonzero syndrome, even overall parity) raises only `dec_double` and returns the data bits exactly as received, uncorrected.
- R9: A codeword with a syndrome above 71 and odd overall parity raises only `dec_double` and returns the received data bits uncorrected.
- R10: After the first output update following reset, exactly one of `dec_clean`, `dec_fixed`, `dec_double` is high. At no time are two of them high together.
- R11: With `REG_OUT` = 1:
  - Every output presents the result for the inputs sampled at the previous rising clock edge, and holds it until the next edge.
  - While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output registers |
| rst_n | input | 1 | Active-low reset of the output registers |
| enc_byte_in | input | 8x8 | Data lanes to encode; lane j holds d(8j)..d(8j+7) |
| enc_word_out | output | 9x8 | Encoded codeword; lane j holds positions 8j..8j+7 |
| dec_word_in | input | 9x8 | Codeword to decode; lane j holds positions 8j..8j+7 |
| dec_byte_out | output | 8x8 | Decoded data lanes |
| dec_clean | output | 1 | Codeword had no error |
| dec_fixed | output | 1 | One error was found and repaired |
| dec_double | output | 1 | Uncorrectable error; data returned raw |

## Verification
The encoder and the decoder are separate datapaths behind one output register, so an encode and a decode always complete in the same cycle. The bench provokes this on purpose in every step. It drives fresh data into the encoder while it drives the decoder a corrupted codeword. That codeword comes from the bench's own encoder model, with chosen flips for the single-error, parity-bit, double-error and out-of-range-syndrome cases. Each side is judged separately, one edge later, against the bench model: the codeword on one side, and the data and verdict flags on the other. A leak between the two paths, or a wrong latency on either, therefore shows up as a mismatch.

// File: rtl/secded_pkg.sv
package secded_pkg;

    localparam int LANE_W     = 8;
    localparam int DATA_LANES = 8;
    localparam int CODE_LANES = 9;
    localparam int DATA_W     = LANE_W * DATA_LANES;
    localparam int CODE_W     = LANE_W * CODE_LANES;
    localparam int SYN_W      = $clog2(CODE_W);

    typedef enum logic [1:0] {
        VERDICT_CLEAN  = 2'd0,
        VERDICT_FIXED  = 2'd1,
        VERDICT_DOUBLE = 2'd2
    } verdict_e;

    // Position 0 and every power of two carry check bits.
    function automatic bit is_check_pos(input int p);
        return (p == 0) || ((p & (p - 1)) == 0);
    endfunction

    // Scatter data bits into the non-check positions in ascending order.
    function automatic logic [CODE_W-1:0] place_data(input logic [DATA_W-1:0] d);
        logic [CODE_W-1:0] w;
        int n;
        w = '0;
        n = 0;
        for (int p = 0; p < CODE_W; p++) begin
            if (!is_check_pos(p)) begin
                w[p] = d[n];
                n++;
            end
        end
        return w;
    endfunction

    // Gather data bits back from the non-check positions.
    function automatic logic [DATA_W-1:0] gather_data(input logic [CODE_W-1:0] w);
        logic [DATA_W-1:0] d;
        int n;
        d = '0;
        n = 0;
        for (int p = 0; p < CODE_W; p++) begin
            if (!is_check_pos(p)) begin
                d[n] = w[p];
                n++;
            end
        end
        return d;
    endfunction

    // Full encode: group parities at 2^k, then overall parity at 0.
    function automatic logic [CODE_W-1:0] build_codeword(input logic [DATA_W-1:0] d);
        logic [CODE_W-1:0] w;
        logic par;
        w = place_data(d);
        for (int k = 0; k < SYN_W; k++) begin
            par = 1'b0;
            for (int p = 1; p < CODE_W; p++) begin
                if (((p >> k) & 1) == 1) par = par ^ w[p];
            end
            w[1 << k] = par;
        end
        w[0] = ^w[CODE_W-1:1];
        return w;
    endfunction

endpackage

// File: rtl/secded_encoder.sv
module secded_encoder
    import secded_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [CODE_W-1:0] word_o
);

    logic [CODE_W-1:0] placed;
    logic [SYN_W-1:0]  group_par;
    logic [CODE_W-1:0] with_groups;

    assign placed = place_data(data_i);

    // One parity tree per check group.
    for (genvar k = 0; k < SYN_W; k++) begin : g_group
        always_comb begin
            group_par[k] = 1'b0;
            for (int p = 1; p < CODE_W; p++) begin
                if (((p >> k) & 1) == 1) group_par[k] = group_par[k] ^ placed[p];
            end
        end
    end

    always_comb begin
        with_groups = placed;
        for (int k = 0; k < SYN_W; k++) begin
            with_groups[1 << k] = group_par[k];
        end
    end

    assign word_o = {with_groups[CODE_W-1:1], ^with_groups[CODE_W-1:1]};

endmodule

// File: rtl/secded_syndrome.sv
module secded_syndrome
    import secded_pkg::*;
(
    input  logic [CODE_W-1:0] word_i,
    output logic [SYN_W-1:0]  syn_o,
    output logic              odd_o
);

    for (genvar k = 0; k < SYN_W; k++) begin : g_syn
        always_comb begin
            syn_o[k] = 1'b0;
            for (int p = 1; p < CODE_W; p++) begin
                if (((p >> k) & 1) == 1) syn_o[k] = syn_o[k] ^ word_i[p];
            end
        end
    end

    assign odd_o = ^word_i;

endmodule

// File: rtl/secded_corrector.sv
module secded_corrector
    import secded_pkg::*;
(
    input  logic [CODE_W-1:0] word_i,
    input  logic [SYN_W-1:0]  syn_i,
    input  logic              odd_i,
    output logic [DATA_W-1:0] data_o,
    output verdict_e          verdict_o
);

    logic [CODE_W-1:0] repaired;
    logic              syn_nz;
    logic              syn_in_range;

    assign syn_nz       = (syn_i != '0);
    assign syn_in_range = (int'(syn_i) < CODE_W);

    always_comb begin
        repaired  = word_i;
        verdict_o = VERDICT_CLEAN;
        unique case ({syn_nz, odd_i})
            2'b00: verdict_o = VERDICT_CLEAN;
            2'b01: begin
                verdict_o   = VERDICT_FIXED;
                repaired[0] = ~word_i[0];
            end
            2'b11: begin
                if (syn_in_range) begin
                    verdict_o       = VERDICT_FIXED;
                    repaired[syn_i] = ~word_i[syn_i];
                end else begin
                    verdict_o = VERDICT_DOUBLE;
                end
            end
            2'b10: verdict_o = VERDICT_DOUBLE;
            default: verdict_o = VERDICT_DOUBLE;
        endcase
    end

    assign data_o = gather_data(repaired);

endmodule

// File: rtl/secded_outstage.sv
module secded_outstage #(
    parameter int W       = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q_o <= '0;
            else        q_o <= d_i;
        end
    end else begin : g_pass
        assign q_o = d_i;
    end

endmodule

// File: rtl/secded72_codec.sv
module secded72_codec
    import secded_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [DATA_LANES-1:0][LANE_W-1:0] enc_byte_in,
    output logic [CODE_LANES-1:0][LANE_W-1:0] enc_word_out,
    input  logic [CODE_LANES-1:0][LANE_W-1:0] dec_word_in,
    output logic [DATA_LANES-1:0][LANE_W-1:0] dec_byte_out,
    output logic                             dec_clean,
    output logic                             dec_fixed,
    output logic                             dec_double
);

    localparam int FLAG_W = 3;
    localparam int STAGE_W = CODE_W + DATA_W + FLAG_W;

    logic [DATA_W-1:0]  enc_data;
    logic [CODE_W-1:0]  enc_word;
    logic [CODE_W-1:0]  dec_word;
    logic [SYN_W-1:0]   syn;
    logic               odd;
    logic [DATA_W-1:0]  dec_data;
    verdict_e           verdict;
    logic [FLAG_W-1:0]  flags;
    logic [STAGE_W-1:0] stage_d;
    logic [STAGE_W-1:0] stage_q;

    assign enc_data = enc_byte_in;
    assign dec_word = dec_word_in;

    secded_encoder u_enc (
        .data_i (enc_data),
        .word_o (enc_word)
    );

    secded_syndrome u_syn (
        .word_i (dec_word),
        .syn_o  (syn),
        .odd_o  (odd)
    );

    secded_corrector u_fix (
        .word_i    (dec_word),
        .syn_i     (syn),
        .odd_i     (odd),
        .data_o    (dec_data),
        .verdict_o (verdict)
    );

    always_comb begin
        unique case (verdict)
            VERDICT_CLEAN:  flags = 3'b100;
            VERDICT_FIXED:  flags = 3'b010;
            VERDICT_DOUBLE: flags = 3'b001;
            default:        flags = 3'b001;
        endcase
    end

    assign stage_d = {enc_word, dec_data, flags};

    secded_outstage #(
        .W       (STAGE_W),
        .REG_OUT (REG_OUT)
    ) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (stage_d),
        .q_o   (stage_q)
    );

    assign {enc_word_out, dec_byte_out, dec_clean, dec_fixed, dec_double} = stage_q;

endmodule

// File: rtl/secded72_codec_chk.sv
module secded72_codec_chk
    import secded_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [DATA_LANES-1:0][LANE_W-1:0] enc_byte_in,
    input logic [CODE_LANES-1:0][LANE_W-1:0] enc_word_out,
    input logic [CODE_LANES-1:0][LANE_W-1:0] dec_word_in,
    input logic [DATA_LANES-1:0][LANE_W-1:0] dec_byte_out,
    input logic                             dec_clean,
    input logic                             dec_fixed,
    input logic                             dec_double
);

    logic              primed;
    logic [DATA_W-1:0] ref_data;
    logic [CODE_W-1:0] ref_word;
    logic [CODE_W-1:0] out_word;
    logic [DATA_W-1:0] out_data;

    assign out_word = enc_word_out;
    assign out_data = dec_byte_out;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    if (REG_OUT) begin : g_ref_reg
        always_ff @(posedge clk) begin
            ref_data <= enc_byte_in;
            ref_word <= dec_word_in;
        end
    end else begin : g_ref_now
        assign ref_data = enc_byte_in;
        assign ref_word = dec_word_in;
    end

    // R1: the data scattered into the codeword is the data that was given
    a_r1_data_roundtrip: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> (gather_data(out_word) == ref_data));

    // R3: the whole codeword has even parity
    a_r3_word_even: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> (^out_word == 1'b0));

    // R10: never more than one verdict at once
    a_r10_flags_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dec_clean, dec_fixed, dec_double}));

    // R10: once outputs are live, a verdict is always given
    a_r10_flag_present: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> $onehot({dec_clean, dec_fixed, dec_double}));

    // R5: a clean verdict returns the received data on a valid codeword
    a_r5_clean_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && dec_clean) |-> ((out_data == gather_data(ref_word)) && (^ref_word == 1'b0)));

    // R6: a repaired word is exactly one bit away from what was received
    a_r6_fixed_one_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && dec_fixed) |-> ($countones(build_codeword(out_data) ^ ref_word) == 1));

    // R8: a double verdict returns the raw data bits
    a_r8_double_raw: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && dec_double) |-> (out_data == gather_data(ref_word)));

endmodule

bind secded72_codec secded72_codec_chk #(.REG_OUT(REG_OUT)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enc_byte_in  (enc_byte_in),
    .enc_word_out (enc_word_out),
    .dec_word_in  (dec_word_in),
    .dec_byte_out (dec_byte_out),
    .dec_clean    (dec_clean),
    .dec_fixed    (dec_fixed),
    .dec_double   (dec_double)
);

// File: tb/tb_secded72_codec.sv
`timescale 1ns/1ps
module tb_secded72_codec;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [7:0][7:0] enc_byte_in;
    logic [8:0][7:0] enc_word_out;
    logic [8:0][7:0] dec_word_in;
    logic [7:0][7:0] dec_byte_out;
    logic            dec_clean, dec_fixed, dec_double;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;
    int pos_map[64];

    always #2 clk = ~clk;

    secded72_codec dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .enc_byte_in  (enc_byte_in),
        .enc_word_out (enc_word_out),
        .dec_word_in  (dec_word_in),
        .dec_byte_out (dec_byte_out),
        .dec_clean    (dec_clean),
        .dec_fixed    (dec_fixed),
        .dec_double   (dec_double)
    );

    // Model: data positions are the non-power-of-two indices above zero.
    function automatic void build_map();
        int n = 0;
        for (int p = 1; p < 72; p++) begin
            if ((p & (p - 1)) != 0) begin
                pos_map[n] = p;
                n++;
            end
        end
    endfunction

    // Model encoder: the group parities equal the XOR of the set data positions.
    function automatic logic [71:0] m_encode(input logic [63:0] d);
        logic [71:0] w = '0;
        logic [6:0]  s = '0;
        for (int i = 0; i < 64; i++) begin
            if (d[i]) begin
                w[pos_map[i]] = 1'b1;
                s = s ^ 7'(pos_map[i]);
            end
        end
        for (int k = 0; k < 7; k++) w[1 << k] = s[k];
        w[0] = ^w;
        return w;
    endfunction

    function automatic logic [63:0] m_extract(input logic [71:0] w);
        logic [63:0] d;
        for (int i = 0; i < 64; i++) d[i] = w[pos_map[i]];
        return d;
    endfunction

    task automatic check(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive both sides at a falling edge and wait one full cycle for the result.
    task automatic step(input logic [63:0] d, input logic [71:0] w);
        enc_byte_in = d;
        dec_word_in = w;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n       = 1'b0;
        enc_byte_in = 64'hFFFF_0000_1234_5678;
        dec_word_in = 72'h12_3456_789A_BCDE_F012;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(enc_word_out == '0, "R11 reset enc", enc_word_out, 72'h0);
        check({dec_byte_out, dec_clean, dec_fixed, dec_double} == '0, "R11 reset dec",
              {5'h0, dec_byte_out, dec_clean, dec_fixed, dec_double}, 72'h0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_clean();
        logic [63:0] pats [5] = '{64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF,
                                  64'h8000_0000_0000_0001, 64'hDEAD_BEEF_CAFE_F00D};
        foreach (pats[i]) begin
            logic [71:0] cw;
            cw = m_encode(pats[i]);
            step(pats[i], cw);
            check(enc_word_out == cw, "R1 R2 R3 codeword", enc_word_out, cw);
            check(^enc_word_out == 1'b0, "R3 overall parity", {71'h0, ^enc_word_out}, 72'h0);
            check(dec_byte_out == pats[i], "R5 clean data", {8'h0, dec_byte_out}, {8'h0, pats[i]});
            check({dec_clean, dec_fixed, dec_double} == 3'b100, "R5 R10 clean flags",
                  {69'h0, dec_clean, dec_fixed, dec_double}, 72'h4);
        end
    endtask

    task automatic t_lanes();
        logic [63:0] d;
        d = 64'h1;
        step(d, m_encode(d));
        check(enc_word_out[0][3] == 1'b1, "R1 R4 d0 at lane0 bit3", {64'h0, enc_word_out[0]}, 72'h8);
        d = 64'h8000_0000_0000_0000;
        step(d, m_encode(d));
        check(enc_word_out[8][7] == 1'b1, "R1 R4 d63 at lane8 bit7", {64'h0, enc_word_out[8]}, 72'h80);
        check(dec_byte_out[7] == 8'h80, "R4 decode lane7", {64'h0, dec_byte_out[7]}, 72'h80);
        d = 64'h0 | (64'h1 << 42);
        step(d, m_encode(d));
        check(dec_byte_out[5] == 8'h04, "R4 decode lane5 bit2", {64'h0, dec_byte_out[5]}, 72'h4);
    endtask

    task automatic t_single();
        logic [63:0] d = 64'hA5C3_0F96_5A3C_F069;
        logic [71:0] base;
        base = m_encode(d);
        for (int p = 1; p < 72; p++) begin
            step(64'h0, base ^ (72'h1 << p));
            check(dec_byte_out == d, "R6 single repair data", {8'h0, dec_byte_out}, {8'h0, d});
            check({dec_clean, dec_fixed, dec_double} == 3'b010, "R6 single repair flags",
                  {69'h0, dec_clean, dec_fixed, dec_double}, 72'h2);
        end
    endtask

    task automatic t_p0();
        logic [63:0] d = 64'h0F0F_1234_FEDC_0001;
        step(d, m_encode(d) ^ 72'h1);
        check(dec_byte_out == d, "R7 p0 error data", {8'h0, dec_byte_out}, {8'h0, d});
        check({dec_clean, dec_fixed, dec_double} == 3'b010, "R7 p0 error flags",
              {69'h0, dec_clean, dec_fixed, dec_double}, 72'h2);
        check(enc_word_out == m_encode(d), "R1 encode beside p0 decode", enc_word_out, m_encode(d));
    endtask

    task automatic t_double();
        int pa [5] = '{3, 0, 64, 10, 70};
        int pb [5] = '{5, 71, 1, 40, 71};
        logic [63:0] d = 64'h1357_9BDF_2468_ACE0;
        foreach (pa[i]) begin
            logic [71:0] w;
            w = m_encode(d) ^ (72'h1 << pa[i]) ^ (72'h1 << pb[i]);
            step(~d, w);
            check(dec_byte_out == m_extract(w), "R8 double raw data", {8'h0, dec_byte_out}, {8'h0, m_extract(w)});
            check({dec_clean, dec_fixed, dec_double} == 3'b001, "R8 double flags",
                  {69'h0, dec_clean, dec_fixed, dec_double}, 72'h1);
            check(enc_word_out == m_encode(~d), "R1 encode beside double decode", enc_word_out, m_encode(~d));
        end
    endtask

    task automatic t_beyond();
        // Three flips including p0: syndromes 72, 80 and 96, overall parity odd.
        int fa [3] = '{8, 16, 32};
        logic [63:0] d = 64'hFACE_0000_0000_BEEF;
        foreach (fa[i]) begin
            logic [71:0] w;
            w = m_encode(d) ^ 72'h1 ^ (72'h1 << fa[i]) ^ (72'h1 << 64);
            step(d, w);
            check(dec_byte_out == m_extract(w), "R9 out-of-range raw data", {8'h0, dec_byte_out}, {8'h0, m_extract(w)});
            check({dec_clean, dec_fixed, dec_double} == 3'b001, "R9 out-of-range flags",
                  {69'h0, dec_clean, dec_fixed, dec_double}, 72'h1);
        end
    endtask

    task automatic t_latency();
        logic [63:0] d1 = 64'h1111_2222_3333_4444;
        logic [63:0] d2 = 64'h5555_6666_7777_8888;
        step(d1, m_encode(d1));
        enc_byte_in = d2;
        dec_word_in = m_encode(d2) ^ (72'h1 << 9);
        #1;
        check(enc_word_out == m_encode(d1), "R11 hold before edge", enc_word_out, m_encode(d1));
        check(dec_clean == 1'b1, "R11 verdict held before edge", {71'h0, dec_clean}, 72'h1);
        @(negedge clk);
        check(enc_word_out == m_encode(d2), "R11 update after edge", enc_word_out, m_encode(d2));
        check(dec_fixed == 1'b1 && dec_byte_out == d2, "R11 R6 decode after edge",
              {8'h0, dec_byte_out}, {8'h0, d2});
    endtask

    initial begin
        build_map();
        t_reset();
        t_clean();
        t_lanes();
        t_single();
        t_p0();
        t_double();
        t_beyond();
        t_latency();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=%h expected=%h", 72'h0, 72'h1);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule